// File: doc/BRIEF.md
# Frequency Lock Detector with PPM Hysteresis

This block decides whether a local oscillator runs at the same frequency as an incoming data stream. Both sides arrive as single-cycle tick pulses on a reference-rate sample clock. One tick marks a group of oscillator cycles and the other marks a group of data transitions. Over a fixed window of `WIN_LEN` sample clocks the block counts the ticks from each side. At the end of the window it turns the difference between the two counts into a frequency error in parts per million. This uses cross-multiplication, so no divider is needed.

The error thresholds are asymmetric. An error larger than `LOSS_PPM` declares loss of lock. An error at or below `LOCK_PPM` declares lock. Any error between the two leaves the state unchanged. While lock is lost, the block raises the enable for the coarse frequency-acquisition loop. When lock is regained, it drops that enable, and the phase loop outside this block finishes the pull-in.

The loss-of-lock pin can work in one of two modes:
- **Live mode:** the pin follows the live status.
- **Sticky mode:** the pin holds a latched flag. The flag is set by any loss of lock and stays set until software raises the clear control and then lowers it again.

With the default 4096-clock window and a reference clock of roughly 25 MHz, one window plus the decision takes well under 200 µs.

Top module: `freq_lock_monitor`

## Requirements
- R1: Reset leaves the block in loss of lock: `lock_status`, `fll_en` and `lol_pin` are all 1.
- R2: When a window ends with |osc−data|·1,000,000 > data·LOSS_PPM, `lock_status` becomes 1. With the default 4096-tick data count, a difference of 5 ticks qualifies.
- R3: When a window ends with a nonzero data count and |osc−data|·1,000,000 ≤ data·LOCK_PPM, `lock_status` becomes 0. A difference of 1 tick in a 4096-clock window qualifies.
- R4: A window whose error lies between the two thresholds (differences of 2 to 4 ticks) leaves `lock_status` unchanged, whether it was 0 or 1.
- R5: A window that counts zero data ticks is treated as loss of lock, whatever the oscillator count.
- R6: `fll_en` is 1 exactly while `lock_status` is 1.
- R7: With `static_lol` = 0, `lol_pin` equals `lock_status`.
- R8: With `static_lol` = 1, `lol_pin` goes to 1 in the same cycle that `lock_status` goes to 1. It then stays 1 after lock returns, until it is cleared.
- R9: The sticky flag clears only on a 1-to-0 transition of `lol_clr`. Holding `lol_clr` high has no effect. A clear while lock is still lost leaves `lol_pin` at 1.
- R10: `lock_status` changes only on a window boundary. A stimulus change in mid-window does not move it before that window ends.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Reference-rate sample clock |
| rst | input | 1 | Synchronous active-high reset |
| osc_tick | input | 1 | One-cycle pulse per oscillator cycle group |
| data_tick | input | 1 | One-cycle pulse per data transition group |
| static_lol | input | 1 | 1 = pin shows the latched loss flag, 0 = pin shows the live status |
| lol_clr | input | 1 | Sticky clear control; acts on its falling edge |
| lol_pin | output | 1 | Loss-of-lock pin level, active high |
| lock_status | output | 1 | Live status: 1 = acquiring, 0 = locked |
| fll_en | output | 1 | Enable for the coarse frequency-acquisition loop |

## Verification
The assertions assume that each tick input is a level sampled once per clock, so a window can never hold more than `WIN_LEN` ticks per side. They also assume that the mode and clear inputs are synchronous to the sample clock. The stimulus drops ticks from a steady one-per-clock stream at fixed positions in a period equal to the window length. Because of this, every window, including one that straddles a pattern change, holds an exact and known count. Pattern changes are made on the falling clock edge, so they never race the counting edge.

// File: rtl/lockdet_pkg.sv
package lockdet_pkg;

    // Scale between a relative error and its ppm value.
    localparam int unsigned PPM_UNIT = 1_000_000;

    // Outcome of one measurement window.
    typedef enum logic [1:0] {
        VERD_HOLD = 2'd0,
        VERD_LOSS = 2'd1,
        VERD_LOCK = 2'd2
    } verdict_e;

    typedef struct packed {
        logic     valid;
        verdict_e kind;
    } verdict_t;

    // Width needed to count up to n inclusive.
    function automatic int cnt_width(input int n);
        return $clog2(n + 1);
    endfunction

endpackage

// File: rtl/lockdet_evcount.sv
module lockdet_evcount #(
    parameter int CNT_W = 13
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             tick,
    input  logic             wrap,
    output logic [CNT_W-1:0] total
);
    logic [CNT_W-1:0] cnt;

    // Running total including the tick of the current cycle.
    assign total = cnt + {{(CNT_W-1){1'b0}}, tick};

    always_ff @(posedge clk) begin
        if (rst || wrap) begin
            cnt <= '0;
        end else begin
            cnt <= total;
        end
    end

    AST_NO_WRAP_SKIP: assert property (@(posedge clk) disable iff (rst)
        wrap |=> (cnt == '0)) else $error("counter did not restart"); // R10

endmodule

// File: rtl/lockdet_window.sv
module lockdet_window #(
    parameter int WIN_LEN = 4096,
    parameter int CNT_W   = 13
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             osc_tick,
    input  logic             data_tick,
    output logic             res_valid,
    output logic [CNT_W-1:0] res_osc,
    output logic [CNT_W-1:0] res_data
);
    localparam int WC_W = (WIN_LEN > 2) ? $clog2(WIN_LEN) : 1;
    localparam logic [WC_W-1:0] LAST = WC_W'(WIN_LEN - 1);

    logic [WC_W-1:0]  wcnt;
    logic             last;
    logic [1:0]       ticks;
    logic [CNT_W-1:0] totals [2];

    assign last  = (wcnt == LAST);
    assign ticks = {data_tick, osc_tick};

    always_ff @(posedge clk) begin
        if (rst || last) begin
            wcnt <= '0;
        end else begin
            wcnt <= wcnt + 1'b1;
        end
    end

    // One identical counter per side: index 0 oscillator, index 1 data.
    for (genvar g = 0; g < 2; g++) begin : g_side
        lockdet_evcount #(.CNT_W(CNT_W)) u_cnt (
            .clk   (clk),
            .rst   (rst),
            .tick  (ticks[g]),
            .wrap  (last),
            .total (totals[g])
        );
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            res_valid <= 1'b0;
            res_osc   <= '0;
            res_data  <= '0;
        end else begin
            res_valid <= last;
            if (last) begin
                res_osc  <= totals[0];
                res_data <= totals[1];
            end
        end
    end

    AST_WIN_SPACING: assert property (@(posedge clk) disable iff (rst)
        res_valid |=> !res_valid) else $error("back-to-back window results"); // R10
    AST_COUNT_BOUND: assert property (@(posedge clk) disable iff (rst)
        res_valid |-> (res_osc <= CNT_W'(WIN_LEN) && res_data <= CNT_W'(WIN_LEN)))
        else $error("window count exceeds window length"); // R2

endmodule

// File: rtl/lockdet_judge.sv
module lockdet_judge
    import lockdet_pkg::*;
#(
    parameter int CNT_W    = 13,
    parameter int LOSS_PPM = 1000,
    parameter int LOCK_PPM = 250
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             res_valid,
    input  logic [CNT_W-1:0] res_osc,
    input  logic [CNT_W-1:0] res_data,
    output verdict_t         verdict
);
    // Products of a count with a ppm constant below 2^20.
    localparam int PW = CNT_W + 21;

    logic [CNT_W-1:0] diff;
    logic [PW-1:0]    err_scaled;
    logic [PW-1:0]    loss_lim;
    logic [PW-1:0]    lock_lim;
    logic             no_data;
    verdict_e         kind_d;

    assign diff       = (res_osc >= res_data) ? (res_osc - res_data)
                                              : (res_data - res_osc);
    assign err_scaled = PW'(diff) * PW'(PPM_UNIT);
    assign loss_lim   = PW'(res_data) * PW'(LOSS_PPM);
    assign lock_lim   = PW'(res_data) * PW'(LOCK_PPM);
    assign no_data    = (res_data == '0);

    always_comb begin
        if (no_data || err_scaled > loss_lim) begin
            kind_d = VERD_LOSS;
        end else if (err_scaled <= lock_lim) begin
            kind_d = VERD_LOCK;
        end else begin
            kind_d = VERD_HOLD;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            verdict <= '{valid: 1'b0, kind: VERD_HOLD};
        end else begin
            verdict.valid <= res_valid;
            verdict.kind  <= res_valid ? kind_d : VERD_HOLD;
        end
    end

    AST_ZERO_DATA_LOSS: assert property (@(posedge clk) disable iff (rst)
        (res_valid && res_data == '0) |=> (verdict.valid && verdict.kind == VERD_LOSS))
        else $error("empty data window not judged as loss"); // R5
    AST_EQUAL_LOCKS: assert property (@(posedge clk) disable iff (rst)
        (res_valid && res_data != '0 && res_osc == res_data)
        |=> (verdict.kind == VERD_LOCK)) else $error("zero error not judged as lock"); // R3

endmodule

// File: rtl/lockdet_state.sv
module lockdet_state
    import lockdet_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  verdict_t verdict,
    input  logic     static_lol,
    input  logic     lol_clr,
    output logic     live,
    output logic     lol_pin,
    output logic     fll_en
);
    logic live_d;
    logic sticky;
    logic clr_q;
    logic clr_fall;

    always_comb begin
        live_d = live;
        if (verdict.valid) begin
            case (verdict.kind)
                VERD_LOSS: live_d = 1'b1;
                VERD_LOCK: live_d = 1'b0;
                default:   live_d = live;
            endcase
        end
    end

    assign clr_fall = clr_q && !lol_clr;

    always_ff @(posedge clk) begin
        if (rst) begin
            live   <= 1'b1;
            sticky <= 1'b1;
            clr_q  <= 1'b0;
        end else begin
            live   <= live_d;
            sticky <= live_d || (sticky && !clr_fall);
            clr_q  <= lol_clr;
        end
    end

    assign lol_pin = static_lol ? sticky : live;
    assign fll_en  = live;

    AST_LOSS_SETS: assert property (@(posedge clk) disable iff (rst)
        (verdict.valid && verdict.kind == VERD_LOSS) |=> live)
        else $error("loss verdict ignored"); // R2
    AST_LOCK_CLEARS: assert property (@(posedge clk) disable iff (rst)
        (verdict.valid && verdict.kind == VERD_LOCK) |=> !live)
        else $error("lock verdict ignored"); // R3
    AST_HOLD_KEEPS: assert property (@(posedge clk) disable iff (rst)
        (!verdict.valid || verdict.kind == VERD_HOLD) |=> $stable(live))
        else $error("status moved without a decision"); // R4
    AST_ONLY_AT_WINDOW: assert property (@(posedge clk) disable iff (rst)
        !$stable(live) |-> $past(verdict.valid))
        else $error("status changed off a window boundary"); // R10
    AST_STICKY_FOLLOWS_LOSS: assert property (@(posedge clk) disable iff (rst)
        live |-> sticky) else $error("sticky flag missed a loss"); // R8
    AST_STICKY_HOLDS: assert property (@(posedge clk) disable iff (rst)
        (sticky && !(clr_q && !lol_clr)) |=> sticky)
        else $error("sticky flag dropped without a falling clear"); // R9

endmodule

// File: rtl/freq_lock_monitor.sv
module freq_lock_monitor
    import lockdet_pkg::*;
#(
    parameter int WIN_LEN  = 4096,
    parameter int LOSS_PPM = 1000,
    parameter int LOCK_PPM = 250
) (
    input  logic clk,
    input  logic rst,
    input  logic osc_tick,
    input  logic data_tick,
    input  logic static_lol,
    input  logic lol_clr,
    output logic lol_pin,
    output logic lock_status,
    output logic fll_en
);
    localparam int CNT_W = cnt_width(WIN_LEN);

    logic             res_valid;
    logic [CNT_W-1:0] res_osc;
    logic [CNT_W-1:0] res_data;
    verdict_t         verdict;

    lockdet_window #(.WIN_LEN(WIN_LEN), .CNT_W(CNT_W)) u_window (
        .clk       (clk),
        .rst       (rst),
        .osc_tick  (osc_tick),
        .data_tick (data_tick),
        .res_valid (res_valid),
        .res_osc   (res_osc),
        .res_data  (res_data)
    );

    lockdet_judge #(.CNT_W(CNT_W), .LOSS_PPM(LOSS_PPM), .LOCK_PPM(LOCK_PPM)) u_judge (
        .clk       (clk),
        .rst       (rst),
        .res_valid (res_valid),
        .res_osc   (res_osc),
        .res_data  (res_data),
        .verdict   (verdict)
    );

    lockdet_state u_state (
        .clk        (clk),
        .rst        (rst),
        .verdict    (verdict),
        .static_lol (static_lol),
        .lol_clr    (lol_clr),
        .live       (lock_status),
        .lol_pin    (lol_pin),
        .fll_en     (fll_en)
    );

    AST_FLL_TRACKS: assert property (@(posedge clk) disable iff (rst)
        !$stable(lock_status) |-> !$stable(fll_en))
        else $error("acquisition enable out of step"); // R6
    AST_LIVE_PIN: assert property (@(posedge clk) disable iff (rst)
        (!static_lol) |-> (lol_pin == lock_status))
        else $error("pin differs from live status in live mode"); // R7

endmodule

// File: tb/freq_lock_monitor_test.sv
module freq_lock_monitor_test;
    localparam int WIN = 4096;
    localparam int NV  = 13;
    // Per vector: oscillator drops, data drops, data silenced, expected status, requirement.
    localparam int VEC_OSC [NV] = '{0, 2, 4, 5, 2, 4, 1, 0, 0, 0, 0, 0, 0};
    localparam int VEC_DAT [NV] = '{0, 0, 0, 0, 0, 0, 0, 5, 2, 1, 4, 0, 0};
    localparam int VEC_OFF [NV] = '{0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 1, 0};
    localparam int VEC_EXP [NV] = '{0, 0, 0, 1, 1, 1, 0, 1, 1, 0, 0, 1, 0};
    localparam int VEC_REQ [NV] = '{3, 4, 4, 2, 4, 4, 3, 2, 4, 3, 4, 5, 3};

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic osc_tick = 1'b0;
    logic data_tick = 1'b0;
    logic static_lol = 1'b0;
    logic lol_clr = 1'b0;
    logic lol_pin, lock_status, fll_en;

    int total = 0;
    int bad = 0;
    int ph = 0;
    int osc_drop = 0;
    int data_drop = 0;
    bit data_off = 1'b0;
    bit finished = 1'b0;

    always #10 clk = ~clk;

    freq_lock_monitor uut (
        .clk         (clk),
        .rst         (rst),
        .osc_tick    (osc_tick),
        .data_tick   (data_tick),
        .static_lol  (static_lol),
        .lol_clr     (lol_clr),
        .lol_pin     (lol_pin),
        .lock_status (lock_status),
        .fll_en      (fll_en)
    );

    function automatic string req_name(input int r);
        case (r)
            2:       return "R2";
            3:       return "R3";
            4:       return "R4";
            default: return "R5";
        endcase
    endfunction

    task automatic check(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic settle();
        repeat (2 * WIN + 8) @(negedge clk);
    endtask

    task automatic wait_phase(input int p);
        while (ph != p) @(negedge clk);
    endtask

    // Tick generator: drops fall at fixed positions in a period equal to the window.
    initial begin
        forever begin
            @(negedge clk);
            if (rst) ph = 0;
            else     ph = (ph + 1) % WIN;
            osc_tick  = (ph >= osc_drop);
            data_tick = !data_off && (ph >= data_drop);
        end
    end

    initial begin
        repeat (195000) @(posedge clk);
        if (!finished) begin
            total++;
            bad++;
            $display("FAIL watchdog: actual=%0d expected=%0d", 0, 1);
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;
        repeat (2) @(negedge clk);
        check(lock_status == 1'b1, "R1", lock_status, 1);
        check(fll_en == 1'b1, "R1", fll_en, 1);
        check(lol_pin == 1'b1, "R1", lol_pin, 1);

        // Table walk, live pin mode.
        for (int i = 0; i < NV; i++) begin
            osc_drop  = VEC_OSC[i];
            data_drop = VEC_DAT[i];
            data_off  = VEC_OFF[i][0];
            settle();
            check(lock_status == VEC_EXP[i][0], req_name(VEC_REQ[i]), lock_status, VEC_EXP[i]);
            check(fll_en == lock_status, "R6", fll_en, lock_status);
            check(lol_pin == lock_status, "R7", lol_pin, lock_status);
        end

        // Locked now; sticky flag still holds the earlier loss.
        static_lol = 1'b1;
        repeat (2) @(negedge clk);
        check(lol_pin == 1'b1, "R8", lol_pin, 1);
        static_lol = 1'b0;
        repeat (2) @(negedge clk);
        check(lol_pin == 1'b0, "R7", lol_pin, 0);

        // Level of the clear does nothing; its falling edge clears.
        static_lol = 1'b1;
        lol_clr = 1'b1;
        repeat (10) @(negedge clk);
        check(lol_pin == 1'b1, "R9", lol_pin, 1);
        lol_clr = 1'b0;
        repeat (3) @(negedge clk);
        check(lol_pin == 1'b0, "R9", lol_pin, 0);

        // Mid-window loss of data: nothing moves until the window closes.
        wait_phase(1000);
        data_off = 1'b1;
        wait_phase(3000);
        check(lock_status == 1'b0, "R10", lock_status, 0);
        check(lol_pin == 1'b0, "R10", lol_pin, 0);
        settle();
        check(lock_status == 1'b1, "R5", lock_status, 1);
        check(lol_pin == 1'b1, "R8", lol_pin, 1);
        check(fll_en == 1'b1, "R6", fll_en, 1);

        // Lock returns; the sticky pin stays high.
        data_off = 1'b0;
        osc_drop = 1;
        settle();
        check(lock_status == 1'b0, "R3", lock_status, 0);
        check(lol_pin == 1'b1, "R8", lol_pin, 1);

        // A clear while lock is still lost has no lasting effect.
        osc_drop = 5;
        settle();
        check(lock_status == 1'b1, "R2", lock_status, 1);
        lol_clr = 1'b1;
        repeat (2) @(negedge clk);
        lol_clr = 1'b0;
        repeat (3) @(negedge clk);
        check(lol_pin == 1'b1, "R9", lol_pin, 1);

        // Back to lock, then clear.
        osc_drop = 0;
        settle();
        check(lol_pin == 1'b1, "R8", lol_pin, 1);
        lol_clr = 1'b1;
        repeat (2) @(negedge clk);
        lol_clr = 1'b0;
        repeat (3) @(negedge clk);
        check(lol_pin == 1'b0, "R9", lol_pin, 0);

        finished = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule